// File: doc/BRIEF.md
# Single-Line NMI Trigger Controller

This block handles one external non-maskable interrupt line for a processor. The raw pin is first brought into the clock domain. It is then compared against a trigger condition that software picks from four modes: low level, falling edge, high level or rising edge. A qualifying condition latches a sticky pending flag. The flag drives the single interrupt output only while the enable bit is set.

Software reaches three word registers through a plain port with address, write data, write strobe and combinational read data:

- **Control word.** Bits [1:0] select the trigger mode. All higher bits are free storage.
- **Pending flag.** Bit 0 holds the flag. Writing a 1 to bit 0 clears it.
- **Enable bit.** The address of this register is set by a parameter, because the block is integrated at two different enable offsets.

Top module: `nmi_line_ctrl`

## Requirements
- R1: The pin passes through SYNC_STAGES (default 2) flops; with the trigger satisfied, a pin change driven between edges is visible in the pending flag after the third rising clock edge and not after the second.
- R2: Control bits [1:0] select the trigger: 0 = pin low, 1 = high-to-low transition, 2 = pin high, 3 = low-to-high transition.
- R3: In the two level modes the pending flag is set on every cycle the level holds, so a clear issued while the level is still active leaves the flag at 1.
- R4: In the two edge modes a steady pin never sets the pending flag; only a transition in the selected direction does.
- R5: Writing 1 to bit 0 of the pending register (offset 0x04) clears the flag; writing 0 there leaves it unchanged. A read returns the flag in bit 0 and zeros elsewhere.
- R6: When a trigger event and a clear write fall in the same cycle, the flag ends up set.
- R7: irq_out is 1 exactly when the pending flag is 1 and bit 0 of the enable register is 1.
- R8: The control register (offset 0x00) stores all DATA_W bits and reads them back unchanged; bits above [1:0] have no effect on triggering.
- R9: The enable register sits at parameter ENA_OFFSET (default 0x08); with ENA_OFFSET = 0x34 it answers at 0x34 and offset 0x08 reads 0.
- R10: While reset is held, the control word, pending flag and enable bit read 0 and irq_out is 0.
- R11: Reads from any offset other than control, pending and enable return 0, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle it is high |
| rd_data | output | DATA_W | Combinational read data for addr |
| nmi_pin | input | 1 | Asynchronous external interrupt pin |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
The bench targets several corner cases, each tied to a specific failure:

- **Clear while a level is active.** A design that treats level modes like edges would drop the flag.
- **Clear in the same cycle as a fresh edge.** If clear were given priority, the event would be lost.
- **Steady pins in edge modes.** A loose detector would raise false pending flags.
- **Exact synchroniser latency.** An extra or missing flop shifts the edge on which the flag appears.
- **Mode decoding with upper control bits set.** A design that decoded more than two bits would select the wrong trigger.
- **Unmapped offsets.** A partial address decode would alias a register there.
- **Second instance with the enable register moved.** If the offset were hard-wired, the enable would answer at the wrong address.

// File: rtl/nmi_ctrl_pkg.sv
// Shared definitions for the single-line NMI controller.
// Assumes byte offsets fit in the address width chosen by the top module.
package nmi_ctrl_pkg;

    // Trigger selection held in control bits [1:0]
    typedef enum logic [1:0] {
        TRIG_LOW  = 2'd0,
        TRIG_FALL = 2'd1,
        TRIG_HIGH = 2'd2,
        TRIG_RISE = 2'd3
    } trig_mode_e;

    // Fixed register offsets; the enable offset is a top parameter
    localparam int OFF_CTRL = 'h00;
    localparam int OFF_PEND = 'h04;

    // Width of the trigger field at the bottom of the control word
    localparam int TRIG_W = 2;

endpackage

// File: rtl/nmi_pin_sync.sv
// Brings the asynchronous pin into the clock domain through a chain of
// STAGES flops and keeps one more flop holding the previous synchronised
// sample for edge comparison. Assumes STAGES >= 2. All flops reset to 0.
module nmi_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_cur,
    output logic pin_prev
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw pin through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_async};
        end
    end

    // Remember the last synchronised sample for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= chain_q[STAGES-1];
        end
    end

    assign pin_cur  = chain_q[STAGES-1];
    assign pin_prev = prev_q;

endmodule

// File: rtl/nmi_trig_detect.sv
// Decides, each cycle, whether the synchronised pin satisfies the selected
// trigger. Level modes look at the current sample only; edge modes compare
// current and previous samples. Purely combinational.
module nmi_trig_detect
    import nmi_ctrl_pkg::*;
(
    input  trig_mode_e mode,
    input  logic       pin_cur,
    input  logic       pin_prev,
    output logic       event_hit
);

    logic rise_seen;
    logic fall_seen;

    // Derive both transition directions from the two samples
    always_comb begin
        rise_seen = pin_cur & ~pin_prev;
        fall_seen = ~pin_cur & pin_prev;
    end

    // Select the condition that the programmed mode asks for
    always_comb begin
        unique case (mode)
            TRIG_LOW:  event_hit = ~pin_cur;
            TRIG_FALL: event_hit = fall_seen;
            TRIG_HIGH: event_hit = pin_cur;
            TRIG_RISE: event_hit = rise_seen;
            default:   event_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/nmi_reg_bank.sv
// Holds the control word, the sticky pending flag and the enable bit, and
// provides combinational read-back. A trigger event outranks a clear write
// in the same cycle. Assumes ENA_OFFSET differs from the two fixed offsets.
module nmi_reg_bank
    import nmi_ctrl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int ENA_OFFSET = 'h08
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              event_hit,
    output trig_mode_e        mode,
    output logic              pend_q,
    output logic              ena_q,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);
    localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(ENA_OFFSET);

    logic [DATA_W-1:0] ctrl_q;
    logic              sel_ctrl;
    logic              sel_pend;
    logic              sel_ena;
    logic              clr_req;

    // Decode which register the current address points at
    always_comb begin
        sel_ctrl = (addr == A_CTRL);
        sel_pend = (addr == A_PEND);
        sel_ena  = (addr == A_ENA);
        clr_req  = wr_en & sel_pend & wdata[0];
    end

    // Control word: full-width storage written as a whole
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en && sel_ctrl) begin
            ctrl_q <= wdata;
        end
    end

    // Enable bit: only bit 0 is kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ena_q <= 1'b0;
        end else if (wr_en && sel_ena) begin
            ena_q <= wdata[0];
        end
    end

    // Pending flag: set by events, cleared by write-one, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (event_hit) begin
            pend_q <= 1'b1;
        end else if (clr_req) begin
            pend_q <= 1'b0;
        end
    end

    // Only the low field of the control word selects the trigger
    assign mode = trig_mode_e'(ctrl_q[TRIG_W-1:0]);

    // Read mux; unmapped offsets return zero
    always_comb begin
        rd_data = '0;
        if (sel_ctrl) begin
            rd_data = ctrl_q;
        end else if (sel_pend) begin
            rd_data[0] = pend_q;
        end else if (sel_ena) begin
            rd_data[0] = ena_q;
        end
    end

endmodule

// File: rtl/nmi_line_ctrl.sv
// Top level of the single-line NMI controller: synchroniser, trigger
// detector and register bank, with the output gated by the enable bit.
// Assumes one interrupt source and a synchronous active-low reset.
module nmi_line_ctrl
    import nmi_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int ENA_OFFSET  = 'h08,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    output logic [DATA_W-1:0] rd_data,
    input  logic              nmi_pin,
    output logic              irq_out
);

    logic       pin_cur;
    logic       pin_prev;
    logic       det_evt;
    logic       pend_q;
    logic       ena_bit;
    trig_mode_e mode;

    nmi_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (nmi_pin),
        .pin_cur   (pin_cur),
        .pin_prev  (pin_prev)
    );

    nmi_trig_detect u_detect (
        .mode      (mode),
        .pin_cur   (pin_cur),
        .pin_prev  (pin_prev),
        .event_hit (det_evt)
    );

    nmi_reg_bank #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .ENA_OFFSET (ENA_OFFSET)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (addr),
        .wdata     (wdata),
        .wr_en     (wr_en),
        .event_hit (det_evt),
        .mode      (mode),
        .pend_q    (pend_q),
        .ena_q     (ena_bit),
        .rd_data   (rd_data)
    );

    // Interrupt request follows the pending flag only while enabled
    assign irq_out = pend_q & ena_bit;

endmodule

// File: rtl/nmi_ctrl_checker.sv
// Temporal checks on the NMI controller, attached to every instance by bind.
module nmi_ctrl_checker #(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int ENA_OFFSET = 'h08
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic              wbit0,
    input logic              wr_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_out,
    input logic              pend_q,
    input logic              ena_q,
    input logic              evt
);

    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'('h04);
    localparam logic [ADDR_W-1:0] A_ENA  = ADDR_W'(ENA_OFFSET);

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> pend_q); // R6

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_PEND && wbit0 && !evt) |=> !pend_q); // R5

    AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !evt) |=> !pend_q); // R4

    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ena_q |-> !irq_out); // R7

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr != '0 && addr != A_PEND && addr != A_ENA) |-> rd_data == '0); // R11

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (!pend_q && !ena_q && !irq_out)); // R10

endmodule

bind nmi_line_ctrl nmi_ctrl_checker #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .ENA_OFFSET (ENA_OFFSET)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wbit0   (wdata[0]),
    .wr_en   (wr_en),
    .rd_data (rd_data),
    .irq_out (irq_out),
    .pend_q  (pend_q),
    .ena_q   (ena_bit),
    .evt     (det_evt)
);

// File: tb/sim_nmi_line_ctrl.sv
module sim_nmi_line_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        wr_en = 1'b0;
    logic        nmi_pin = 1'b0;
    logic [31:0] rd_data;
    logic [31:0] rd_data1;
    logic        irq_out;
    logic        irq_out1;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    nmi_line_ctrl u0 (
        .clk (clk), .rst_n (rst_n), .addr (addr), .wdata (wdata),
        .wr_en (wr_en), .rd_data (rd_data), .nmi_pin (nmi_pin),
        .irq_out (irq_out)
    );

    nmi_line_ctrl #(.ENA_OFFSET('h34)) u1 (
        .clk (clk), .rst_n (rst_n), .addr (addr), .wdata (wdata),
        .wr_en (wr_en), .rd_data (rd_data1), .nmi_pin (nmi_pin),
        .irq_out (irq_out1)
    );

    // Vector fields: mode[5:4], pin before[3], pin after[2], enable[1], expected pending[0]
    localparam logic [5:0] VEC [16] = '{
        6'b00_0_0_1_1, 6'b00_0_1_0_1, 6'b00_1_0_1_1, 6'b00_1_1_0_0,
        6'b01_0_0_1_0, 6'b01_0_1_0_0, 6'b01_1_0_1_1, 6'b01_1_1_0_0,
        6'b10_0_0_1_0, 6'b10_0_1_0_1, 6'b10_1_0_1_1, 6'b10_1_1_0_1,
        6'b11_0_0_1_0, 6'b11_0_1_0_1, 6'b11_1_0_1_0, 6'b11_1_1_0_0
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge: issue one write, return at the next negedge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        nmi_pin = 1'b1;
        settle(3);
        // R10: reset state
        rd(8'h00, d); chk("R10 ctrl", d, 32'h0);
        rd(8'h04, d); chk("R10 pend", d, 32'h0);
        rd(8'h08, d); chk("R10 ena", d, 32'h0);
        chk("R10 irq", {31'b0, irq_out}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        settle(4);

        // R2 R3 R4 R7: vector table walk
        for (int i = 0; i < 16; i++) begin
            wr(8'h00, {30'b0, VEC[i][5:4]});
            wr(8'h08, {31'b0, VEC[i][1]});
            nmi_pin = VEC[i][3];
            settle(5);
            nmi_pin = VEC[i][2];
            wr(8'h04, 32'h1);
            settle(5);
            rd(8'h04, d);
            chk("R2/R3/R4 pending", d, {31'b0, VEC[i][0]});
            chk("R7 irq", {31'b0, irq_out}, {31'b0, VEC[i][0] & VEC[i][1]});
        end

        // R1: latency of exactly three edges in high-level mode
        wr(8'h00, 32'h2);
        nmi_pin = 1'b0;
        settle(4);
        wr(8'h04, 32'h1);
        addr = 8'h04;
        nmi_pin = 1'b1;
        @(negedge clk); #1; chk("R1 edge1", rd_data, 32'h0);
        @(negedge clk); #1; chk("R1 edge2", rd_data, 32'h0);
        @(negedge clk); #1; chk("R1 edge3", rd_data, 32'h1);

        // R5: writing 0 leaves pending, writing 1 clears (rising mode, steady pin)
        wr(8'h00, 32'h3);
        settle(3);
        wr(8'h04, 32'h0);
        rd(8'h04, d); chk("R5 write0 keeps", d, 32'h1);
        wr(8'h04, 32'h1);
        rd(8'h04, d); chk("R5 write1 clears", d, 32'h0);

        // R6: clear in the same cycle as a rising edge event
        nmi_pin = 1'b0;
        settle(4);
        wr(8'h04, 32'h1);
        nmi_pin = 1'b1;
        @(negedge clk);
        @(negedge clk);
        wr(8'h04, 32'h1);
        rd(8'h04, d); chk("R6 set wins", d, 32'h1);

        // R8: upper bits stored, mode decodes only [1:0] (0xFFFFFFF6 -> high level)
        wr(8'h00, 32'hFFFF_FFF6);
        rd(8'h00, d); chk("R8 readback", d, 32'hFFFF_FFF6);
        settle(3);
        wr(8'h04, 32'h1);
        settle(2);
        rd(8'h04, d); chk("R8 high level active", d, 32'h1);
        nmi_pin = 1'b0;
        settle(4);
        wr(8'h04, 32'h1);
        settle(3);
        rd(8'h04, d); chk("R8 high level idle", d, 32'h0);

        // R11: unmapped offset reads 0, writes change nothing
        wr(8'h08, 32'h1);
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, d); chk("R11 unmapped read", d, 32'h0);
        rd(8'h00, d); chk("R11 ctrl untouched", d, 32'hFFFF_FFF6);
        rd(8'h08, d); chk("R11 ena untouched", d, 32'h1);

        // R9: moved enable offset on the second instance
        wr(8'h34, 32'h1);
        addr = 8'h34; #1;
        chk("R9 u1 ena at 0x34", rd_data1, 32'h1);
        chk("R9 u0 0x34 unmapped", rd_data, 32'h0);
        addr = 8'h08; #1;
        chk("R9 u1 0x08 unmapped", rd_data1, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule